// File: doc/BRIEF.md
# Flash command interface controller

This block is the command front end of a word-wide, block-erasable nonvolatile memory. The array sits on chip as a small parameterised memory that keeps its block structure. The word address arrives multiplexed on one bus, in the way a DRAM receives it. The block captures the upper half when a row strobe falls and the lower half when a column strobe falls. The top bits of the assembled address select the block. Command and data words enter on a write strobe and go to a decoder, which tracks two-write sequences.

A program takes a setup command followed by the data word. An erase takes a setup command followed by a confirm code. Before an operation runs, two checks apply: a lock bit kept for each block, and a programming-voltage-valid input. After a confirmed operation the controller holds a busy period. It then either updates the array or records an error in a status register, and reads return that status until software selects array reads again. A program can only clear bits, and an erase sets a whole block to all ones.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode, every word reads 0xFFFF, all lock bits are clear, `ready` is 1 and the status register reads 0x0080.
- R2: The address bus value present when `ras_n` is first seen low becomes the upper address half, and the value present when `cas_n` is first seen low becomes the lower half. The word address is {row, column}, and its top log2(BLOCKS) bits select the block.
- R3: Command 0x40, then a data write, starts a program. On completion the addressed word becomes the old word ANDed with the data.
- R4: Command 0x20, then a write whose low byte is 0xD0, starts a block erase. On completion every word of the addressed block is 0xFFFF and every other block is unchanged.
- R5: `ready` is low for exactly BUSY_CYC clock cycles, starting with the edge that accepts the confirming write. While busy, reads return the status with bit 7 at 0.
- R6: While busy, every write is ignored. This includes 0xFF and any setup code, and the mode after completion is still status.
- R7: After a program or erase completes, reads return the status (dout = {8'h00, status}) until command 0xFF is written.
- R8: In an erase sequence, a second write other than 0xD0 aborts the erase. It sets status bits 5 and 4, starts no busy period and leaves the array unchanged.
- R9: Command 0x60 followed by 0x01 locks the addressed block, and 0x60 followed by 0xD0 unlocks it. A program or erase aimed at a locked block leaves the array unchanged and sets status bit 1, together with bit 4 for a program or bit 5 for an erase.
- R10: If `vpp_ok` is 0 when the confirming write is accepted, the operation leaves the array unchanged and sets status bit 3, together with bit 4 for a program or bit 5 for an erase.
- R11: Error bits stay set until command 0x50 clears them. A later operation that succeeds leaves them set.
- R12: Command 0x70 selects status reads and command 0xFF selects array reads. Commands use the low byte of `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe; its falling transition captures the upper address half |
| cas_n | input | 1 | Column strobe; its falling transition captures the lower address half |
| addr_bus | input | ROW_W | Multiplexed address half |
| we_n | input | 1 | Write strobe; its falling transition accepts `din` |
| din | input | 16 | Command or data word |
| vpp_ok | input | 1 | Programming supply above the lockout level |
| dout | output | 16 | Array word or status, depending on mode |
| ready | output | 1 | Low while an operation is busy |

## Verification
The strobes are registered, so a capture or write takes effect on the first rising edge at which the strobe is seen low. The bench changes strobes on falling edges and samples `dout` one nanosecond after a falling edge, after that capture edge has passed. For an array or status read, the result is due in the same cycle that the column half is captured. For a confirmed operation, `ready` falls one edge after the write and rises BUSY_CYC edges later. The bench counts falling edges with `ready` low to check that window. It issues its busy-time write and read within that window.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int BLOCKS    = 32,
  parameter int BLK_WORDS = 32,
  parameter int BUSY_CYC  = 8,
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int OFS_W = $clog2(BLK_WORDS),
  localparam int AW    = BLK_W + OFS_W,
  localparam int COL_W = AW / 2,
  localparam int ROW_W = AW - COL_W,
  localparam int WORDS = BLOCKS * BLK_WORDS,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic [ROW_W-1:0] addr_bus,
  input  logic             we_n,
  input  logic [15:0]      din,
  input  logic             vpp_ok,
  output logic [15:0]      dout,
  output logic             ready
);

  typedef enum logic [1:0] {P_NONE, P_PROG, P_ERASE, P_LOCK} pend_t;

  logic [15:0]      mem [WORDS];
  logic             ras_q, cas_q, we_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  pend_t            pend;
  logic             stat_mode, busy, op_erase, op_vpp_bad, op_locked;
  logic [AW-1:0]    tgt;
  logic [15:0]      wdata;
  logic [CNT_W-1:0] cnt;
  logic [BLOCKS-1:0] lock_q;
  logic             e5, e4, e3, e1;

  wire [AW-1:0]    addr    = {row_q, col_q};
  wire [BLK_W-1:0] blk     = addr[AW-1 -: BLK_W];
  wire             we_fall = we_q & ~we_n;
  wire [7:0]       cmd     = din[7:0];
  wire [7:0]       status  = {~busy, 1'b0, e5, e4, e3, 1'b0, e1, 1'b0};
  wire [3:0]       errs    = {e5, e4, e3, e1};
  wire             clr_cmd = !busy && we_fall && pend == P_NONE && cmd == 8'h50;

  assign ready = ~busy;
  assign dout  = (busy || stat_mode) ? {8'h00, status} : mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1;
      row_q <= '0; col_q <= '0;
      pend <= P_NONE; stat_mode <= 1'b0; busy <= 1'b0;
      op_erase <= 1'b0; op_vpp_bad <= 1'b0; op_locked <= 1'b0;
      tgt <= '0; wdata <= '0; cnt <= '0; lock_q <= '0;
      e5 <= 1'b0; e4 <= 1'b0; e3 <= 1'b0; e1 <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_q && !ras_n) row_q <= addr_bus;
      if (cas_q && !cas_n) col_q <= addr_bus[COL_W-1:0];

      if (busy) begin
        if (cnt == CNT_W'(1)) begin
          busy      <= 1'b0;
          stat_mode <= 1'b1;
          if (op_vpp_bad || op_locked) begin
            if (op_vpp_bad) e3 <= 1'b1;
            else            e1 <= 1'b1;
            if (op_erase) e5 <= 1'b1;
            else          e4 <= 1'b1;
          end else if (op_erase) begin
            for (int i = 0; i < BLK_WORDS; i++)
              mem[{tgt[AW-1 -: BLK_W], OFS_W'(i)}] <= 16'hFFFF;
          end else begin
            mem[tgt] <= mem[tgt] & wdata;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else if (we_fall) begin
        case (pend)
          P_PROG: begin
            busy <= 1'b1; cnt <= CNT_W'(BUSY_CYC); tgt <= addr;
            op_erase <= 1'b0; op_vpp_bad <= ~vpp_ok; op_locked <= lock_q[blk];
            wdata <= din; pend <= P_NONE;
          end
          P_ERASE: begin
            pend <= P_NONE;
            stat_mode <= 1'b1;
            if (cmd == 8'hD0) begin
              busy <= 1'b1; cnt <= CNT_W'(BUSY_CYC); tgt <= addr;
              op_erase <= 1'b1; op_vpp_bad <= ~vpp_ok; op_locked <= lock_q[blk];
            end else begin
              e5 <= 1'b1; e4 <= 1'b1;
            end
          end
          P_LOCK: begin
            pend <= P_NONE;
            stat_mode <= 1'b1;
            if (cmd == 8'h01)      lock_q[blk] <= 1'b1;
            else if (cmd == 8'hD0) lock_q[blk] <= 1'b0;
            else begin e5 <= 1'b1; e4 <= 1'b1; end
          end
          default: begin
            case (cmd)
              8'hFF: stat_mode <= 1'b0;
              8'h70: stat_mode <= 1'b1;
              8'h50: begin e5 <= 1'b0; e4 <= 1'b0; e3 <= 1'b0; e1 <= 1'b0; end
              8'h40: pend <= P_PROG;
              8'h20: pend <= P_ERASE;
              8'h60: pend <= P_LOCK;
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  // R5
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && cnt <= CNT_W'(BUSY_CYC)));

  // R3
  prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == CNT_W'(1) && !op_erase) |=> ((mem[tgt] & ~$past(mem[tgt])) == 16'h0000));

  // R9
  inhibited_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == CNT_W'(1) && (op_locked || op_vpp_bad)) |=> $stable(mem[tgt]));

  // R6
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we_fall) |=> ($stable(lock_q) && pend == $past(pend)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> ((errs & $past(errs)) == $past(errs)));

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int COL_W = 5;
  localparam int ROW_W = 5;
  localparam int BUSY  = 8;

  logic clk = 1'b0, rst_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, vpp_ok = 1'b1;
  logic [ROW_W-1:0] addr_bus = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic ready;
  logic rd_strobe = 1'b0;
  int total = 0, bad = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.BLOCKS(32), .BLK_WORDS(32), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .addr_bus(addr_bus),
    .we_n(we_n), .din(din), .vpp_ok(vpp_ok), .dout(dout), .ready(ready));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rd_strobe) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, dout, e);
    end
  end

  task automatic put_addr(input int a);
    @(negedge clk); addr_bus = ROW_W'(a >> COL_W); ras_n = 1'b0;
    @(negedge clk); addr_bus = ROW_W'(a & 31); cas_n = 1'b0;
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1;
  endtask

  task automatic wpulse(input logic [15:0] d);
    @(negedge clk); din = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    put_addr(a);
    wpulse(d);
  endtask

  task automatic rd(input int a, input logic [15:0] e, input string tag);
    put_addr(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic wait_ready;
    while (!ready) @(negedge clk);
  endtask

  localparam int A = 'h045;
  localparam int B = 'h0A3;

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {15'h0, ready}, 16'h0001);
    rd(A, 16'hFFFF, "R1 erased word");
    wr(0, 16'h0070);
    rd(0, 16'h0080, "R1 R12 reset status");
    wr(0, 16'h00FF);

    wr(A, 16'h0040); wr(A, 16'h1234); wait_ready;
    rd(A, 16'h0080, "R7 status after program");
    wr(0, 16'h00FF);
    rd(A, 16'h1234, "R3 R2 programmed word");
    rd(A + 1, 16'hFFFF, "R2 neighbour word");

    wr(A, 16'h0040); wr(A, 16'hFF0F); wait_ready; wr(0, 16'h00FF);
    rd(A, 16'h1204, "R3 AND of old and new");

    begin
      int n;
      wr(B, 16'h0040); wr(B, 16'hABCD);
      n = 0;
      while (!ready) begin n++; @(negedge clk); end
      chk("R5 busy length", 16'(n), 16'(BUSY));
    end
    wr(0, 16'h00FF);
    rd(B, 16'hABCD, "R3 second block");

    wr(A + 2, 16'h0040); wr(A + 2, 16'h00F0);
    wpulse(16'h00FF);
    rd(0, 16'h0000, "R5 status while busy");
    wait_ready;
    rd(0, 16'h0080, "R6 write during busy ignored");
    wr(0, 16'h00FF);
    rd(A + 2, 16'h00F0, "R3 third word");

    wr(A, 16'h0020); wr(A, 16'h00D0); wait_ready;
    rd(0, 16'h0080, "R4 status after erase");
    wr(0, 16'h00FF);
    rd(A, 16'hFFFF, "R4 erased word");
    rd(A + 2, 16'hFFFF, "R4 erased other word");
    rd(B, 16'hABCD, "R4 other block kept");

    wr(A, 16'h0040); wr(A, 16'h5555); wait_ready;
    wr(A, 16'h0020); wr(A, 16'h0033);
    chk("R8 no busy", {15'h0, ready}, 16'h0001);
    rd(0, 16'h00B0, "R8 sequence error status");
    wr(0, 16'h00FF);
    rd(A, 16'h5555, "R8 array unchanged");
    wr(0, 16'h0050); wr(0, 16'h0070);
    rd(0, 16'h0080, "R11 clear status");

    wr(A, 16'h0060); wr(A, 16'h0001);
    rd(0, 16'h0080, "R9 lock set status");
    wr(A, 16'h0040); wr(A, 16'h0000); wait_ready;
    rd(0, 16'h0092, "R9 locked program status");
    wr(0, 16'h00FF);
    rd(A, 16'h5555, "R9 locked word kept");
    wr(0, 16'h0050);
    wr(A, 16'h0020); wr(A, 16'h00D0); wait_ready;
    rd(0, 16'h00A2, "R9 locked erase status");
    wr(0, 16'h00FF);
    rd(A, 16'h5555, "R9 locked block not erased");
    wr(0, 16'h0050);
    wr(B, 16'h0040); wr(B, 16'h0F0F); wait_ready; wr(0, 16'h00FF);
    rd(B, 16'h0B0D, "R9 unlocked block programs");
    wr(A, 16'h0060); wr(A, 16'h00D0);
    wr(A, 16'h0040); wr(A, 16'h0F0F); wait_ready;
    rd(0, 16'h0080, "R9 after unlock status");
    wr(0, 16'h00FF);
    rd(A, 16'h0505, "R9 unlocked word programs");

    vpp_ok = 1'b0;
    wr(B, 16'h0040); wr(B, 16'h0000); wait_ready;
    rd(0, 16'h0098, "R10 program lockout status");
    wr(0, 16'h00FF);
    rd(B, 16'h0B0D, "R10 word kept");
    wr(0, 16'h0050);
    wr(B, 16'h0020); wr(B, 16'h00D0); wait_ready;
    rd(0, 16'h00A8, "R10 erase lockout status");
    wr(0, 16'h00FF);
    rd(B, 16'h0B0D, "R10 block kept");
    vpp_ok = 1'b1;

    wr(B, 16'h0040); wr(B, 16'h00FF); wait_ready;
    rd(0, 16'h00A8, "R11 bits stay after success");
    wr(0, 16'h00FF);
    rd(B, 16'h000D, "R11 later program applied");
    wr(0, 16'h0050); wr(0, 16'h0070);
    rd(0, 16'h0080, "R11 R12 cleared");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule